// File: doc/BRIEF.md
# PWM Fault Shutdown Controller

This block sits between the compare outputs of a PWM timer and the output pins. Each pin is normally driven by its compare output while that channel's output-mode field is non-zero. When the field is zero, the pin is driven by its general-purpose port data bit. Software arms the guard and chooses three things: which fault source to watch (an external pin or an analog comparator output), whether that source first passes through a noise filter, and which transition polarity counts as a fault.

Both sources pass through a two-flop synchronizer. The selected source may then go through a filter that changes its output only after four identical samples in a row. An edge detector follows the filter. While the guard is armed, a matching edge does three things in a single clock cycle:
- it clears every output-mode field, so all pins fall back to port data;
- it drops the arm bit;
- it latches an interrupt flag, if interrupts are enabled.

Software can either take the interrupt or poll the arm bit. The timer counter, the comparator and the register bus stay outside the block and appear only as ports.

Top module: `pwm_fault_guard`

## Requirements
- R1: After reset, armed, irqReq and every modeBits bit are 0, and pinOut equals portData.
- R2: A modeWr pulse loads modeWrData into modeBits. modeBits holds 2 bits per channel, with channel n in bits [2n+1:2n]. Pin n shows ocOut[n] when its field is non-zero and portData[n] when its field is zero.
- R3: While armed is 0, edges on either source leave modeBits, armed and irqReq unchanged.
- R4: With ctlSrcSel=0 the fault source is extPin, and with ctlSrcSel=1 it is cmpOut. Transitions on the source that is not selected never cause a fault.
- R5: With ctlEdgeRise=1 only a 0-to-1 transition of the source counts as a fault. With ctlEdgeRise=0 only a 1-to-0 transition counts.
- R6: With the filter off, a source change driven before clock edge 1 takes effect at edge 3. With the filter on, it takes effect at edge 7.
- R7: With ctlFiltEn=1, a source level held for 3 clock cycles or fewer is rejected. A level held for 4 cycles passes.
- R8: On a qualified fault, every modeBits field becomes 0, pinOut becomes portData, and armed falls, all at the same clock edge.
- R9: A fault latches irqReq to 1 when ctlIrqEn was 1 at the last control write. When ctlIrqEn was 0, irqReq stays 0.
- R10: irqReq holds at 1 until an irqAck pulse clears it. A later edge while disarmed does not set it again.
- R11: If a modeWr and a fault land in the same cycle, modeBits becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| extPin | input | 1 | External fault pin, asynchronous |
| cmpOut | input | 1 | Analog comparator result, asynchronous |
| ctlWr | input | 1 | Load strobe for the control fields below |
| ctlArm | input | 1 | Arm value written on ctlWr |
| ctlSrcSel | input | 1 | 0 selects extPin, 1 selects cmpOut |
| ctlFiltEn | input | 1 | Enables the 4-sample noise filter |
| ctlEdgeRise | input | 1 | 1 selects rising edges, 0 selects falling edges |
| ctlIrqEn | input | 1 | Enables the fault interrupt flag |
| modeWr | input | 1 | Load strobe for output-mode fields |
| modeWrData | input | 8 | New output-mode fields, 2 bits per channel |
| ocOut | input | 4 | Compare outputs from the timer |
| portData | input | 4 | General-purpose port data bits |
| irqAck | input | 1 | One-cycle interrupt acknowledge |
| pinOut | output | 4 | Driven PWM pins |
| modeBits | output | 8 | Current output-mode fields |
| armed | output | 1 | Arm bit, readable for polling |
| irqReq | output | 1 | Latched fault interrupt request |

## Verification
With the filter off, results are due three clock edges after an input change at a falling edge: two synchronizer stages, then the edge registers the clear. The filter adds four edges to this. The latency checks sample at the falling edge just before the due edge, where the guard must still be armed, and again at the falling edge just after it, where it must be cleared. Every other input changes at a falling edge, and every output is read at a falling edge after a settle window much longer than the seven-edge worst case. The same-cycle race is set up by raising modeWr in exactly the cycle before the third edge.

// File: rtl/fault_guard_pkg.sv
package fault_guard_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic clrModes;
  } ctlStrobes_t;

  // conditions from datapath to control
  typedef struct packed {
    logic faultEdge;
  } dpFlags_t;

endpackage

// File: rtl/fault_dp.sv
module fault_dp
  import fault_guard_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int MODE_W    = 2,
  parameter int SYNC_LEN  = 2,
  parameter int FILT_LEN  = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     extPin,
  input  logic                     cmpOut,
  input  logic                     srcSel,
  input  logic                     filtEn,
  input  logic                     edgeRise,
  input  logic                     modeWr,
  input  logic [NUM_CH*MODE_W-1:0] modeWrData,
  input  logic [NUM_CH-1:0]        ocOut,
  input  logic [NUM_CH-1:0]        portData,
  input  ctlStrobes_t              strobes,
  output dpFlags_t                 flags,
  output logic [NUM_CH*MODE_W-1:0] modeBits,
  output logic [NUM_CH-1:0]        pinOut
);

  localparam int MODE_BITS = NUM_CH * MODE_W;
  localparam int CNT_W     = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

  logic [SYNC_LEN-1:0]  extSync;
  logic [SYNC_LEN-1:0]  cmpSync;
  logic                 selSync;
  logic                 filtQ;
  logic [CNT_W-1:0]     filtCnt;
  logic                 condSig;
  logic                 prevQ;
  logic                 edgeHit;
  logic [MODE_BITS-1:0] modeQ;

  // both sources are synchronized so a source switch is glitch-free
  always_ff @(posedge clk) begin
    if (!rstN) begin
      extSync <= '0;
      cmpSync <= '0;
    end else begin
      extSync <= {extSync[SYNC_LEN-2:0], extPin};
      cmpSync <= {cmpSync[SYNC_LEN-2:0], cmpOut};
    end
  end

  assign selSync = srcSel ? cmpSync[SYNC_LEN-1] : extSync[SYNC_LEN-1];

  // noise filter: follows the input only after FILT_LEN equal samples
  always_ff @(posedge clk) begin
    if (!rstN) begin
      filtQ   <= 1'b0;
      filtCnt <= '0;
    end else if (selSync == filtQ) begin
      filtCnt <= '0;
    end else if (filtCnt == CNT_LAST) begin
      filtQ   <= selSync;
      filtCnt <= '0;
    end else begin
      filtCnt <= filtCnt + 1'b1;
    end
  end

  assign condSig = filtEn ? filtQ : selSync;

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= condSig;
  end

  assign edgeHit = edgeRise ? (condSig & ~prevQ) : (~condSig & prevQ);
  assign flags.faultEdge = edgeHit;

  // output-mode fields: the fault clear has priority over a write
  always_ff @(posedge clk) begin
    if (!rstN)                 modeQ <= '0;
    else if (strobes.clrModes) modeQ <= '0;
    else if (modeWr)           modeQ <= modeWrData;
  end

  assign modeBits = modeQ;

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_pinMux
      assign pinOut[ch] = (|modeQ[ch*MODE_W +: MODE_W]) ? ocOut[ch] : portData[ch];
    end
  endgenerate

  // R7
  filt_settle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (filtQ != $past(filtQ)) |-> ($past(filtCnt) == CNT_LAST));

  // R11
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrModes |=> (modeBits == '0));

  // R8
  clr_pins_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrModes |=> (pinOut == portData));

endmodule

// File: rtl/fault_ctl.sv
module fault_ctl
  import fault_guard_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctlWr,
  input  logic        ctlArm,
  input  logic        ctlSrcSel,
  input  logic        ctlFiltEn,
  input  logic        ctlEdgeRise,
  input  logic        ctlIrqEn,
  input  logic        irqAck,
  input  dpFlags_t    flags,
  output ctlStrobes_t strobes,
  output logic        srcSel,
  output logic        filtEn,
  output logic        edgeRise,
  output logic        armed,
  output logic        irqReq
);

  logic armedQ;
  logic irqEnQ;
  logic irqQ;
  logic faultHit;

  assign faultHit         = armedQ & flags.faultEdge;
  assign strobes.clrModes = faultHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcSel   <= 1'b0;
      filtEn   <= 1'b0;
      edgeRise <= 1'b1;
      irqEnQ   <= 1'b0;
    end else if (ctlWr) begin
      srcSel   <= ctlSrcSel;
      filtEn   <= ctlFiltEn;
      edgeRise <= ctlEdgeRise;
      irqEnQ   <= ctlIrqEn;
    end
  end

  // self-disarm beats a software write in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN)         armedQ <= 1'b0;
    else if (faultHit) armedQ <= 1'b0;
    else if (ctlWr)    armedQ <= ctlArm;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   irqQ <= 1'b0;
    else if (faultHit && irqEnQ) irqQ <= 1'b1;
    else if (irqAck)             irqQ <= 1'b0;
  end

  assign armed  = armedQ;
  assign irqReq = irqQ;

  // R8
  arm_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armedQ && flags.faultEdge) |=> !armed);

  // R9
  irq_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armedQ && flags.faultEdge && irqEnQ) |=> irqReq);

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !irqAck) |=> irqReq);

  // R3
  irq_disarmed_chk: assert property (@(posedge clk) disable iff (!rstN)
    !armedQ |=> !$rose(irqReq));

endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
  import fault_guard_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int MODE_W   = 2,
  parameter int SYNC_LEN = 2,
  parameter int FILT_LEN = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     extPin,
  input  logic                     cmpOut,
  input  logic                     ctlWr,
  input  logic                     ctlArm,
  input  logic                     ctlSrcSel,
  input  logic                     ctlFiltEn,
  input  logic                     ctlEdgeRise,
  input  logic                     ctlIrqEn,
  input  logic                     modeWr,
  input  logic [NUM_CH*MODE_W-1:0] modeWrData,
  input  logic [NUM_CH-1:0]        ocOut,
  input  logic [NUM_CH-1:0]        portData,
  input  logic                     irqAck,
  output logic [NUM_CH-1:0]        pinOut,
  output logic [NUM_CH*MODE_W-1:0] modeBits,
  output logic                     armed,
  output logic                     irqReq
);

  ctlStrobes_t strobes;
  dpFlags_t    flags;
  logic        srcSel;
  logic        filtEn;
  logic        edgeRise;

  fault_ctl u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .ctlWr       (ctlWr),
    .ctlArm      (ctlArm),
    .ctlSrcSel   (ctlSrcSel),
    .ctlFiltEn   (ctlFiltEn),
    .ctlEdgeRise (ctlEdgeRise),
    .ctlIrqEn    (ctlIrqEn),
    .irqAck      (irqAck),
    .flags       (flags),
    .strobes     (strobes),
    .srcSel      (srcSel),
    .filtEn      (filtEn),
    .edgeRise    (edgeRise),
    .armed       (armed),
    .irqReq      (irqReq)
  );

  fault_dp #(
    .NUM_CH   (NUM_CH),
    .MODE_W   (MODE_W),
    .SYNC_LEN (SYNC_LEN),
    .FILT_LEN (FILT_LEN)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .extPin     (extPin),
    .cmpOut     (cmpOut),
    .srcSel     (srcSel),
    .filtEn     (filtEn),
    .edgeRise   (edgeRise),
    .modeWr     (modeWr),
    .modeWrData (modeWrData),
    .ocOut      (ocOut),
    .portData   (portData),
    .strobes    (strobes),
    .flags      (flags),
    .modeBits   (modeBits),
    .pinOut     (pinOut)
  );

endmodule

// File: tb/tb_pwm_fault_guard.sv
`timescale 1ns/1ps
module tb_pwm_fault_guard;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       extPin = 1'b0, cmpOut = 1'b0;
  logic       ctlWr = 1'b0, ctlArm = 1'b0, ctlSrcSel = 1'b0, ctlFiltEn = 1'b0;
  logic       ctlEdgeRise = 1'b1, ctlIrqEn = 1'b0;
  logic       modeWr = 1'b0;
  logic [7:0] modeWrData = '0;
  logic [3:0] ocOut = 4'b1111;
  logic [3:0] portData = 4'b0101;
  logic       irqAck = 1'b0;
  logic [3:0] pinOut;
  logic [7:0] modeBits;
  logic       armed, irqReq;

  int nChecks = 0;
  int nFails = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  pwm_fault_guard dut (
    .clk(clk), .rstN(rstN), .extPin(extPin), .cmpOut(cmpOut),
    .ctlWr(ctlWr), .ctlArm(ctlArm), .ctlSrcSel(ctlSrcSel), .ctlFiltEn(ctlFiltEn),
    .ctlEdgeRise(ctlEdgeRise), .ctlIrqEn(ctlIrqEn), .modeWr(modeWr),
    .modeWrData(modeWrData), .ocOut(ocOut), .portData(portData), .irqAck(irqAck),
    .pinOut(pinOut), .modeBits(modeBits), .armed(armed), .irqReq(irqReq)
  );

  // {drvCmp, srcSel, filtEn, edgeRise, irqEn, idle, pulseLen[3:0], expFault}
  // pulseLen 0 means the source steps away from idle and stays there
  localparam int NVEC = 10;
  localparam logic [10:0] VEC [NVEC] = '{
    11'b0_0_0_1_1_0_0001_1, // ext rising, irq on
    11'b0_0_0_0_1_1_0001_1, // ext falling
    11'b1_1_0_1_0_0_0010_1, // cmp selected, irq off
    11'b0_1_0_1_1_0_0010_0, // ext driven, cmp selected: ignored
    11'b1_0_0_1_1_0_0010_0, // cmp driven, ext selected: ignored
    11'b0_0_0_1_1_1_0000_0, // wrong polarity step
    11'b0_0_1_1_1_0_0011_0, // filtered, 3-cycle pulse rejected
    11'b0_0_1_1_1_0_0100_1, // filtered, 4-cycle pulse accepted
    11'b1_1_1_0_1_1_0000_1, // cmp filtered falling step
    11'b0_0_1_1_0_0_0000_1  // ext filtered rising step
  };

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ctlWrite(input logic arm, input logic sel, input logic filt,
                          input logic rise, input logic ien);
    ctlArm = arm; ctlSrcSel = sel; ctlFiltEn = filt; ctlEdgeRise = rise; ctlIrqEn = ien;
    ctlWr = 1'b1;
    tick();
    ctlWr = 1'b0;
  endtask

  task automatic modeWrite(input logic [7:0] d);
    modeWrData = d;
    modeWr = 1'b1;
    tick();
    modeWr = 1'b0;
  endtask

  task automatic ackIrq();
    irqAck = 1'b1;
    tick();
    irqAck = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick();

    // R1 reset state
    chk("R1 armed", armed, 0);
    chk("R1 modeBits", modeBits, 0);
    chk("R1 irqReq", irqReq, 0);
    chk("R1 pinOut", pinOut, portData);

    // R2 mixed mode fields: ch0=01, ch1=00, ch2=11, ch3=00
    modeWrite(8'b00_11_00_01);
    chk("R2 modeBits", modeBits, 8'b00_11_00_01);
    chk("R2 pinOut", pinOut, 4'b0101 & 4'b1010 | 4'b0101);

    // R3 edges while disarmed are ignored
    ctlWrite(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    extPin = 1'b1; tick(2); extPin = 1'b0;
    cmpOut = 1'b1; tick(2); cmpOut = 1'b0;
    tick(10);
    chk("R3 modeBits", modeBits, 8'b00_11_00_01);
    chk("R3 irqReq", irqReq, 0);
    chk("R3 armed", armed, 0);

    // vector table: R4 R5 R7 R8 R9
    for (int v = 0; v < NVEC; v++) begin
      logic drvCmp, sel, filt, rise, ien, idle, expF;
      int   plen;
      {drvCmp, sel, filt, rise, ien, idle} = VEC[v][10:5];
      plen = int'(VEC[v][4:1]);
      expF = VEC[v][0];
      ctlWrite(1'b0, sel, filt, rise, ien);
      extPin = idle; cmpOut = idle;
      tick(12);
      modeWrite(8'b10_10_10_10);
      ctlWrite(1'b1, sel, filt, rise, ien);
      if (drvCmp) cmpOut = ~idle; else extPin = ~idle;
      if (plen > 0) begin
        tick(plen);
        extPin = idle; cmpOut = idle;
      end
      tick(12);
      chk($sformatf("R4 R5 R7 R8 vec %0d armed", v), armed, !expF);
      chk($sformatf("R8 R11 vec %0d modeBits", v), modeBits, expF ? 8'h00 : 8'b10_10_10_10);
      chk($sformatf("R8 vec %0d pinOut", v), pinOut, expF ? portData : ocOut);
      chk($sformatf("R9 vec %0d irqReq", v), irqReq, expF & ien);
      ackIrq();
    end

    // R6 latency, unfiltered
    extPin = 1'b0; cmpOut = 1'b0;
    ctlWrite(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    tick(12);
    modeWrite(8'b01_01_01_01);
    ctlWrite(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    extPin = 1'b1;
    tick(2);
    chk("R6 unfiltered early armed", armed, 1);
    chk("R6 unfiltered early modeBits", modeBits, 8'b01_01_01_01);
    tick();
    chk("R6 R8 unfiltered due armed", armed, 0);
    chk("R6 R8 unfiltered due modeBits", modeBits, 0);
    extPin = 1'b0;

    // R6 latency, filtered
    ctlWrite(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    tick(12);
    modeWrite(8'b01_01_01_01);
    ctlWrite(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    extPin = 1'b1;
    tick(6);
    chk("R6 filtered early armed", armed, 1);
    tick();
    chk("R6 filtered due armed", armed, 0);
    chk("R6 filtered due pinOut", pinOut, portData);
    extPin = 1'b0;

    // R11 write and fault in the same cycle
    ctlWrite(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    tick(12);
    modeWrite(8'b10_10_10_10);
    ctlWrite(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    extPin = 1'b1;
    tick(2);
    modeWrData = 8'hFF;
    modeWr = 1'b1;
    tick();
    modeWr = 1'b0;
    chk("R11 modeBits", modeBits, 0);
    chk("R11 armed", armed, 0);
    extPin = 1'b0;

    // R10 flag hold, ack, no re-set while disarmed
    ctlWrite(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    tick(12);
    ctlWrite(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    extPin = 1'b1; tick(2); extPin = 1'b0;
    tick(8);
    chk("R10 set", irqReq, 1);
    tick(10);
    chk("R10 held", irqReq, 1);
    ackIrq();
    chk("R10 cleared", irqReq, 0);
    extPin = 1'b1; tick(2); extPin = 1'b0;
    tick(10);
    chk("R10 no re-set", irqReq, 0);
    chk("R10 still disarmed", armed, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule